// File: doc/BRIEF.md
# Multicycle Register-Transfer Processor Core

This block is a small processor core that runs each instruction as a fixed series of register transfers. It has four special registers: a program counter, an instruction register, a memory address register and a memory buffer register. It also has a sixteen-entry general register file and a two-input adder with operand registers P and Q. Every instruction starts with a three-step fetch and a decode step. It then runs a short execute sequence chosen by the opcode. The supported operations are:

- load a register from an absolute address;
- add two registers;
- write an immediate into a register;
- add an immediate to a register;
- branch when the zero flag is set.

There is one memory read port, and it carries both instruction and data reads. Its address always comes from the memory address register, and read data always lands in the memory buffer register. The request side is a valid/ready channel. The core raises `mem_req_valid` and then holds the request and its address unchanged until a cycle in which `mem_req_ready` is high. The core never withdraws a request it has raised. The response side has no back-pressure: the core is always waiting when a response is due. It takes `mem_rsp_data` in the first cycle in which `mem_rsp_valid` is high after the accepted request. Each register write is announced on a valid-only writeback output. That output cannot be stalled.

Top module: `rtx_core`

## Requirements
- R1: While `rst` is high, the program counter reads 0, the zero flag reads 0 and neither `mem_req_valid` nor `wb_valid` is asserted. The first request after reset is a fetch at address 0.
- R2: The fetch step latches the program counter into the address register and advances the counter by 4. The fetch request is issued at that latched address, and the returned word becomes the instruction. Without a taken branch, successive fetches are 4 apart.
- R3: While `mem_req_valid` is high and `mem_req_ready` is low, the core keeps `mem_req_valid` high and `mem_req_addr` unchanged in the next cycle. A read completes only on its response.
- R4: Opcode 0 (bits [31:28]) is a load. It requests the address formed by zero-extending bits [15:0], then writes the returned word into the destination register (bits [23:20]).
- R5: Opcode 1 first latches P from the first source (bits [19:16]) and Q from the second source (bits [3:0]). It then writes P+Q modulo 2^32 into the destination. Bits [15:4] are ignored.
- R6: Opcode 2 writes the zero-extended bits [15:0] into the destination register.
- R7: Opcode 3 latches P from the first source and Q from the zero-extended bits [15:0]. It then writes P+Q modulo 2^32 into the destination.
- R8: The zero flag changes only on the result write of opcodes 1 and 3. It is set exactly when that result is 0. It is unaffected by loads, immediate writes, branches and no-ops.
- R9: Opcode 4 loads the program counter with the zero-extended bits [15:0] when the zero flag is 1. Otherwise the next fetch is 4 past the branch.
- R10: Opcodes 5 to 15 write no register and return to fetch, so the next fetch is 4 past them.
- R11: With `mem_req_ready` held high and each response one cycle after acceptance, the time between consecutive fetch acceptances is 5 cycles for a no-op, 6 for an immediate write or a branch, 7 for either add and 9 for a load. A writeback pulse lasts one cycle and is followed by a fetch step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_req_valid | output | 1 | Read request pending |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_addr | output | 32 | Read byte address, taken from the address register |
| mem_rsp_valid | input | 1 | Read data present this cycle |
| mem_rsp_data | input | 32 | Read data |
| wb_valid | output | 1 | A register is written this cycle |
| wb_reg | output | 4 | Index of the register written |
| wb_data | output | 32 | Value written |
| pc_o | output | 32 | Current program counter |
| zero_o | output | 1 | Zero flag |

## Verification
With the memory always ready and answering one cycle after acceptance, an instruction's writeback lands 4 (immediate write), 5 (either add) or 7 (load) cycles after its fetch is accepted. The next fetch is accepted 5 to 9 cycles after the previous one, depending on the opcode. The bench stamps every accepted request and every writeback pulse with a cycle count taken on the falling edge. It compares the gaps between fetch acceptances with the per-opcode figures. It compares the order and values of requests and writebacks with a program model built together with the program, so no check depends on a guessed sampling edge. A second run throttles `mem_req_ready` pseudo-randomly. That run checks only order, values and request holding, because the cycle counts then depend on the stall pattern.

// File: rtl/rtx_pkg.sv
package rtx_pkg;

  localparam int OPW = 4;

  localparam logic [OPW-1:0] OP_LOAD = 4'd0;
  localparam logic [OPW-1:0] OP_ADD  = 4'd1;
  localparam logic [OPW-1:0] OP_MOVI = 4'd2;
  localparam logic [OPW-1:0] OP_ADDI = 4'd3;
  localparam logic [OPW-1:0] OP_BEQ  = 4'd4;

  // bit positions of instruction fields
  localparam int OP_LSB  = 28;
  localparam int RD_LSB  = 20;
  localparam int RS1_LSB = 16;
  localparam int RS2_LSB = 0;

  typedef enum logic [3:0] {
    S_F1, S_F2Q, S_F2R, S_F3, S_DEC,
    S_LD1, S_LD2Q, S_LD2R, S_LD3,
    S_RR1, S_RI1, S_ALUWB, S_MOVI, S_BR
  } step_e;

  typedef enum logic [1:0] {
    WB_MBR = 2'd0,
    WB_ALU = 2'd1,
    WB_IMM = 2'd2
  } wbsrc_e;

  typedef struct packed {
    logic   mar_we;
    logic   mar_from_ir;
    logic   pc_inc;
    logic   pc_load;
    logic   req;
    logic   mbr_we;
    logic   ir_we;
    logic   p_we;
    logic   q_we;
    logic   q_from_ir;
    logic   rf_we;
    wbsrc_e rf_src;
    logic   z_we;
  } ctl_t;

endpackage

// File: rtl/rtx_regfile.sv
module rtx_regfile #(
  parameter int NREG = 16,
  parameter int W    = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr_a,
  input  logic [IW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                             regs[i] <= '0;
      else if (we && waddr == IW'(i))      regs[i] <= wdata;
    end

    AST_RF_WRITE: assert property (@(posedge clk) disable iff (rst)
      (we && waddr == IW'(i)) |=> regs[i] == $past(wdata)); // R5
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/rtx_alu.sv
module rtx_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] p,
  input  logic [W-1:0] q,
  output logic [W-1:0] sum,
  output logic         zero
);

  always_comb begin
    sum  = p + q;
    zero = (sum == '0);
  end

endmodule

// File: rtl/rtx_ctrl.sv
module rtx_ctrl
  import rtx_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  input  logic           zf,
  input  logic           req_ready,
  input  logic           rsp_valid,
  output step_e          step,
  output ctl_t           ctl
);

  step_e nxt;

  always_ff @(posedge clk) begin
    if (rst) step <= S_F1;
    else     step <= nxt;
  end

  always_comb begin
    nxt = step;
    ctl = '0;
    unique case (step)
      S_F1: begin
        ctl.mar_we = 1'b1;
        ctl.pc_inc = 1'b1;
        nxt        = S_F2Q;
      end
      S_F2Q: begin
        ctl.req = 1'b1;
        if (req_ready) nxt = S_F2R;
      end
      S_F2R: begin
        if (rsp_valid) begin
          ctl.mbr_we = 1'b1;
          nxt        = S_F3;
        end
      end
      S_F3: begin
        ctl.ir_we = 1'b1;
        nxt       = S_DEC;
      end
      S_DEC: begin
        case (opcode)
          OP_LOAD: nxt = S_LD1;
          OP_ADD:  nxt = S_RR1;
          OP_MOVI: nxt = S_MOVI;
          OP_ADDI: nxt = S_RI1;
          OP_BEQ:  nxt = S_BR;
          default: nxt = S_F1;
        endcase
      end
      S_LD1: begin
        ctl.mar_we      = 1'b1;
        ctl.mar_from_ir = 1'b1;
        nxt             = S_LD2Q;
      end
      S_LD2Q: begin
        ctl.req = 1'b1;
        if (req_ready) nxt = S_LD2R;
      end
      S_LD2R: begin
        if (rsp_valid) begin
          ctl.mbr_we = 1'b1;
          nxt        = S_LD3;
        end
      end
      S_LD3: begin
        ctl.rf_we  = 1'b1;
        ctl.rf_src = WB_MBR;
        nxt        = S_F1;
      end
      S_RR1: begin
        ctl.p_we = 1'b1;
        ctl.q_we = 1'b1;
        nxt      = S_ALUWB;
      end
      S_RI1: begin
        ctl.p_we      = 1'b1;
        ctl.q_we      = 1'b1;
        ctl.q_from_ir = 1'b1;
        nxt           = S_ALUWB;
      end
      S_ALUWB: begin
        ctl.rf_we  = 1'b1;
        ctl.rf_src = WB_ALU;
        ctl.z_we   = 1'b1;
        nxt        = S_F1;
      end
      S_MOVI: begin
        ctl.rf_we  = 1'b1;
        ctl.rf_src = WB_IMM;
        nxt        = S_F1;
      end
      S_BR: begin
        ctl.pc_load = zf;
        nxt         = S_F1;
      end
      default: nxt = S_F1;
    endcase
  end

  AST_WB_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
    ctl.rf_we |=> (step == S_F1) && !ctl.rf_we); // R11

  AST_NOP_RETURNS: assert property (@(posedge clk) disable iff (rst)
    (step == S_DEC && opcode > OP_BEQ) |=> (step == S_F1)); // R10

endmodule

// File: rtl/rtx_core.sv
module rtx_core
  import rtx_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  parameter int IMMW = 16,
  localparam int RIW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [XLEN-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_data,
  output logic            wb_valid,
  output logic [RIW-1:0]  wb_reg,
  output logic [XLEN-1:0] wb_data,
  output logic [XLEN-1:0] pc_o,
  output logic            zero_o
);

  logic [XLEN-1:0] pc_q, ir_q, mar_q, mbr_q, p_q, q_q;
  logic            zf_q;

  step_e step;
  ctl_t  ctl;

  logic [XLEN-1:0] opnd, rf_a, rf_b, alu_sum, rf_wdata;
  logic            alu_zero;
  logic [OPW-1:0]  opcode;
  logic [RIW-1:0]  rd, rs1, rs2;
  logic            unused_ir_bits;

  // instruction field extraction
  assign opcode = ir_q[OP_LSB +: OPW];
  assign rd     = ir_q[RD_LSB +: RIW];
  assign rs1    = ir_q[RS1_LSB +: RIW];
  assign rs2    = ir_q[RS2_LSB +: RIW];
  assign opnd   = {{(XLEN-IMMW){1'b0}}, ir_q[IMMW-1:0]};
  assign unused_ir_bits = ^ir_q[OP_LSB-1:RD_LSB+RIW];

  rtx_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .opcode    (opcode),
    .zf        (zf_q),
    .req_ready (mem_req_ready),
    .rsp_valid (mem_rsp_valid),
    .step      (step),
    .ctl       (ctl)
  );

  rtx_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (ctl.rf_we),
    .waddr   (rd),
    .wdata   (rf_wdata),
    .raddr_a (rs1),
    .raddr_b (rs2),
    .rdata_a (rf_a),
    .rdata_b (rf_b)
  );

  rtx_alu #(.W(XLEN)) u_alu (
    .p    (p_q),
    .q    (q_q),
    .sum  (alu_sum),
    .zero (alu_zero)
  );

  // register-file write source mux
  always_comb begin
    unique case (ctl.rf_src)
      WB_MBR:  rf_wdata = mbr_q;
      WB_ALU:  rf_wdata = alu_sum;
      WB_IMM:  rf_wdata = opnd;
      default: rf_wdata = mbr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
      p_q   <= '0;
      q_q   <= '0;
      zf_q  <= 1'b0;
    end else begin
      if (ctl.pc_inc)       pc_q  <= pc_q + XLEN'(4);
      else if (ctl.pc_load) pc_q  <= opnd;
      if (ctl.mar_we)       mar_q <= ctl.mar_from_ir ? opnd : pc_q;
      if (ctl.mbr_we)       mbr_q <= mem_rsp_data;
      if (ctl.ir_we)        ir_q  <= mbr_q;
      if (ctl.p_we)         p_q   <= rf_a;
      if (ctl.q_we)         q_q   <= ctl.q_from_ir ? opnd : rf_b;
      if (ctl.z_we)         zf_q  <= alu_zero;
    end
  end

  assign mem_req_valid = ctl.req;
  assign mem_req_addr  = mar_q;
  assign wb_valid      = ctl.rf_we;
  assign wb_reg        = rd;
  assign wb_data       = rf_wdata;
  assign pc_o          = pc_q;
  assign zero_o        = zf_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R3

  AST_PC_MOVES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pc_q == $past(pc_q)) || (pc_q == $past(pc_q) + XLEN'(4)) || (pc_q == $past(opnd))); // R2

  AST_Z_ONLY_ALU: assert property (@(posedge clk) disable iff (rst)
    !$stable(zf_q) |-> $past(ctl.z_we)); // R8

  AST_BR_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (step == S_BR && !zf_q) |=> $stable(pc_q)); // R9

endmodule

// File: tb/rtx_core_bench.sv
`timescale 1ns/1ps
module rtx_core_bench;

  localparam int MAXE = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_req_ready = 1'b1;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_req_valid, wb_valid, zero_o;
  logic [31:0] mem_req_addr, wb_data, pc_o;
  logic [3:0]  wb_reg;

  always #10 clk = ~clk;

  rtx_core u_rtx_core (
    .clk(clk), .rst(rst),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .wb_valid(wb_valid), .wb_reg(wb_reg),
    .wb_data(wb_data), .pc_o(pc_o), .zero_o(zero_o)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  logic [31:0] mem [0:1023];
  logic        stall_mode = 1'b0;
  logic [7:0]  lfsr = 8'h5A;

  // memory model: response one cycle after an accepted request
  always @(posedge clk) begin
    cyc <= cyc + 1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_req_ready <= stall_mode ? lfsr[1] : 1'b1;
    mem_rsp_valid <= mem_req_valid && mem_req_ready && !rst;
    mem_rsp_data  <= mem[mem_req_addr[11:2]];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // recorded activity
  int          n_rec = 0, n_rwb = 0;
  logic [31:0] rec_addr [MAXE];
  int          rec_cyc  [MAXE];
  logic [3:0]  rwb_reg  [MAXE];
  logic [31:0] rwb_data [MAXE];
  logic        prev_wait = 1'b0;
  logic [31:0] prev_addr = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_wait)
        chk(mem_req_valid && mem_req_addr == prev_addr, "R3 request held under back-pressure",
            mem_req_addr, prev_addr);
      prev_wait = mem_req_valid && !mem_req_ready;
      prev_addr = mem_req_addr;
      if (mem_req_valid && mem_req_ready && n_rec < MAXE) begin
        rec_addr[n_rec] = mem_req_addr;
        rec_cyc[n_rec]  = cyc;
        n_rec++;
      end
      if (wb_valid && n_rwb < MAXE) begin
        rwb_reg[n_rwb]  = wb_reg;
        rwb_data[n_rwb] = wb_data;
        n_rwb++;
      end
    end else begin
      prev_wait = 1'b0;
    end
  end

  // program model and expected activity
  int          n_exp, n_ewb, last_len;
  logic [31:0] gen_pc;
  logic [31:0] mreg [16];
  logic        mz;
  logic [31:0] exp_addr [MAXE];
  bit          exp_isf  [MAXE];
  int          exp_gap  [MAXE];
  logic [3:0]  ewb_reg  [MAXE];
  logic [31:0] ewb_data [MAXE];
  string       ewb_tag  [MAXE];

  task automatic push_wb(input logic [3:0] rd, input logic [31:0] v, input string tag);
    ewb_reg[n_ewb] = rd; ewb_data[n_ewb] = v; ewb_tag[n_ewb] = tag; n_ewb++;
    mreg[rd] = v;
  endtask

  // op [31:28], rd [23:20], rs1 [19:16], low field [15:0]
  task automatic emit(input logic [3:0] op, input logic [3:0] rd, input logic [3:0] rs1, input logic [15:0] low);
    logic [31:0] r;
    mem[gen_pc[11:2]] = {op, 4'h0, rd, rs1, low};
    exp_addr[n_exp] = gen_pc; exp_isf[n_exp] = 1'b1; exp_gap[n_exp] = last_len; n_exp++;
    gen_pc = gen_pc + 4;
    case (op)
      4'd0: begin
        exp_addr[n_exp] = {16'h0, low}; exp_isf[n_exp] = 1'b0; exp_gap[n_exp] = 0; n_exp++;
        push_wb(rd, mem[low[11:2]], "R4 load"); last_len = 9;
      end
      4'd1: begin
        r = mreg[rs1] + mreg[low[3:0]]; mz = (r == 0);
        push_wb(rd, r, "R5 register add"); last_len = 7;
      end
      4'd2: begin push_wb(rd, {16'h0, low}, "R6 move immediate"); last_len = 6; end
      4'd3: begin
        r = mreg[rs1] + {16'h0, low}; mz = (r == 0);
        push_wb(rd, r, "R7 add immediate"); last_len = 7;
      end
      4'd4: begin
        if (mz) gen_pc = {16'h0, low};
        last_len = 6;
      end
      default: last_len = 5; // R10: no register write
    endcase
  endtask

  task automatic build(input int variant);
    for (int k = 0; k < 1024; k++) mem[k] = 32'h5000_0000;
    for (int k = 0; k < 60; k++) mem[512 + k] = 32'(k) * 32'h9E37_79B1 + 32'(variant) * 32'h0123_4567;
    mem[572] = 32'hFFFF_FFFF; mem[573] = 32'h1;
    mem[574] = 32'h8000_0000; mem[575] = 32'h8000_0000;
    n_exp = 0; n_ewb = 0; last_len = 0; gen_pc = 0; mz = 1'b0;
    for (int k = 0; k < 16; k++) mreg[k] = '0;
    for (int k = 0; k < 16; k++) emit(4'd0, 4'(k), 4'(k * 3), 16'h0800 + 16'(4 * ((k * 7 + variant * 3) % 64)));
    // wrap to zero through a register add, then taken branches
    emit(4'd0, 4'd1, 4'd0, 16'h08F0);
    emit(4'd0, 4'd2, 4'd0, 16'h08F4);
    emit(4'd1, 4'd3, 4'd1, 16'hA5C2);
    emit(4'd4, 4'd0, 4'd0, gen_pc[15:0] + 16'd12);
    for (int op = 5; op < 16; op++) emit(4'(op), 4'd7, 4'd7, 16'h1234);
    emit(4'd4, 4'd0, 4'd0, gen_pc[15:0] + 16'd8);
    emit(4'd2, 4'd9, 4'd0, 16'hABCD);
    emit(4'd0, 4'd10, 4'd0, 16'h08F8);
    emit(4'd4, 4'd0, 4'd0, gen_pc[15:0] + 16'd8);
    for (int a = 0; a < 16; a++) begin
      emit(4'd1, 4'((a + 3) % 16), 4'(a), {12'hF0F, 4'(a)});
      emit(4'd1, 4'((a + 3) % 16), 4'(a), {12'h000, 4'((a + 5) % 16)});
      emit(4'd1, 4'((a + 3) % 16), 4'(a), {12'h3C3, 4'((a + 11) % 16)});
    end
    for (int a = 0; a < 16; a++) emit(4'd3, 4'((a + 1) % 16), 4'(a), 16'(a) * 16'h1111 + 16'(variant));
    emit(4'd3, 4'd11, 4'd12, 16'hFFFF);
    foreach (mem[k]) if (k < 5) emit(4'd2, 4'(k + 4), 4'd0, (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : (k == 2) ? 16'h8000 : (k == 3) ? 16'h7FFF : 16'h1357);
    // wrap to zero through an immediate add
    emit(4'd0, 4'd4, 4'd0, 16'h08F0);
    emit(4'd3, 4'd5, 4'd4, 16'h0001);
    emit(4'd4, 4'd0, 4'd0, gen_pc[15:0] + 16'd16);
    // not-taken branch
    emit(4'd2, 4'd7, 4'd0, 16'h0001);
    emit(4'd3, 4'd8, 4'd7, 16'h0002);
    emit(4'd4, 4'd0, 4'd0, 16'h0700);
    emit(4'd9, 4'd1, 4'd1, 16'h0000);
    emit(4'd1, 4'd6, 4'd0, 16'h0000);
    // park in a taken self-loop
    emit(4'd2, 4'd13, 4'd0, 16'h0000);
    emit(4'd1, 4'd13, 4'd13, 16'h000D);
    emit(4'd4, 4'd0, 4'd0, gen_pc[15:0]);
  endtask

  task automatic run_phase(input int variant, input bit stall);
    int start;
    int pf;
    build(variant);
    rst = 1'b1;
    stall_mode = stall;
    repeat (3) @(negedge clk);
    chk(pc_o == 0, "R1 reset program counter", pc_o, 0);
    chk(!zero_o, "R1 reset zero flag", 32'(zero_o), 0);
    chk(!mem_req_valid && !wb_valid, "R1 no activity in reset", {mem_req_valid, wb_valid}, 0);
    n_rec = 0; n_rwb = 0;
    @(posedge clk); rst = 1'b0;
    start = cyc;
    while (n_rec < n_exp + 3 && (cyc - start) < 40000) @(negedge clk);
    chk(n_rec >= n_exp + 3, "R11 program completes", n_rec, n_exp + 3);
    chk(rec_addr[0] == 0, "R1 first fetch at zero", rec_addr[0], 0);
    pf = -1;
    for (int i = 0; i < n_exp; i++) begin
      chk(rec_addr[i] == exp_addr[i], exp_isf[i] ? "R2 R9 fetch address" : "R4 load address",
          rec_addr[i], exp_addr[i]);
      if (exp_isf[i]) begin
        if (!stall && pf >= 0)
          chk(rec_cyc[i] - rec_cyc[pf] == exp_gap[i], "R11 cycles between fetches",
              rec_cyc[i] - rec_cyc[pf], exp_gap[i]);
        pf = i;
      end
    end
    // loop tail is the self branch
    chk(rec_addr[n_exp] == exp_addr[n_exp - 1], "R9 self-loop refetch", rec_addr[n_exp], exp_addr[n_exp - 1]);
    chk(n_rwb == n_ewb, "R10 writeback count", n_rwb, n_ewb);
    for (int i = 0; i < n_ewb && i < n_rwb; i++) begin
      chk(rwb_reg[i] == ewb_reg[i], {ewb_tag[i], " destination"}, 32'(rwb_reg[i]), 32'(ewb_reg[i]));
      chk(rwb_data[i] == ewb_data[i], {ewb_tag[i], " value"}, rwb_data[i], ewb_data[i]);
    end
    chk(zero_o == 1'b1, "R8 zero flag after zero result", 32'(zero_o), 1);
  endtask

  initial begin
    run_phase(0, 1'b0);
    run_phase(1, 1'b1);
    run_phase(2, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_err++;
    $display("FAIL R11 watchdog expired actual %0d expected %0d", cyc, 150000);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule